// File: doc/BRIEF.md
# Integer ALU with Per-Operation Flag Masking

This block is a registered integer arithmetic and logic unit that keeps a 12-bit status word in the style of a general-purpose processor. Each accepted operation works at one of four operand widths (8, 16, 32 or 64 bits). It produces a result and rewrites only the status bits that the operation is defined to touch. All other status bits keep their previous value. A pipeline or sequencer presents an opcode, a width code and two operands with a one-cycle strobe. The result and the new status word appear after the next rising clock edge.

Increment and decrement leave the carry bit alone. This lets a loop counter advance between multi-word add-with-carry steps without breaking the carry chain. Negate is treated as a subtraction from zero. Logical operations clear the arithmetic error bits. Dedicated operations set, clear or invert the carry bit, and set or clear the direction bit.

Top module: `alu_flagged`

## Requirements
- R1: After a synchronous active-high reset, `result` is 0 and `flags` is 0x002.
- R2: Opcodes ADD=0, ADC=1, SUB=2 and SBB=3 produce the sum or difference masked to the width selected by `size` (0=8, 1=16, 2=32, 3=64 bits). Bits above that width read zero. Carry (flags bit 0) is set on a carry out of the top bit for addition, or a borrow out of it for subtraction. ADC adds the current carry bit, and SBB subtracts it.
- R3: INC=4 adds one and DEC=5 subtracts one. Both update overflow, sign, zero, auxiliary carry and parity, and leave flags bit 0 unchanged. Incrementing 0xFFFF at 16 bits gives 0 with zero set.
- R4: NEG=6 returns zero minus `opA`. Carry is set exactly when the operand at the selected width is nonzero.
- R5: Parity (bit 2) is set when the low 8 bits of the result hold an even number of ones, at every width.
- R6: Auxiliary carry (bit 4) is set by a carry out of bit 3 in additions, or a borrow out of bit 3 in subtractions.
- R7: Sign (bit 7) equals the top bit of the result at the selected width. Zero (bit 6) is set when the whole result at that width is zero.
- R8: Overflow (bit 11) is set by arithmetic operations when the signed result does not fit the selected width.
- R9: AND=7, OR=8 and XOR=9 return the bitwise result. They clear carry, overflow and auxiliary carry, and compute sign, zero and parity from the result.
- R10: STC=10, CLC=11 and CMC=12 set, clear or invert bit 0 only. The result and all other flags are unchanged.
- R11: STD=13 and CLD=14 set or clear direction (bit 10) only. The result and all other flags are unchanged.
- R12: Flag bit 1 always reads one, and bits 3, 5, 8 and 9 always read zero. Cycles without `valid`, and opcode 15, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Operation strobe for the current cycle |
| opcode | input | 4 | Operation code (see R2 to R11) |
| size | input | 2 | Operand width code (0=8, 1=16, 2=32, 3=64 bits) |
| opA | input | DATA_W | First operand (the operand of INC, DEC and NEG) |
| opB | input | DATA_W | Second operand |
| result | output | DATA_W | Registered result, zero above the selected width |
| flags | output | 12 | Registered status word |

## Verification
The hardest state to reach is one where the kept carry bit matters: a carry set by an earlier operation must survive INC or DEC and then feed ADC or SBB. The same goes for a direction bit that persists across arithmetic. Random opcode sequences run back to back without intervening reset, so the status word carries history from operation to operation. Directed sequences force the carry high before an INC that wraps 0xFFFF, and before a NEG of zero. A reference model computes flags from signed and unsigned range arithmetic, not from adder bit positions.

// File: rtl/aluflag_pkg.sv
package aluflag_pkg;
  localparam int FLAG_W = 12;
  localparam int FB_CF = 0;
  localparam int FB_PF = 2;
  localparam int FB_AF = 4;
  localparam int FB_ZF = 6;
  localparam int FB_SF = 7;
  localparam int FB_DF = 10;
  localparam int FB_OF = 11;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_INC = 4'd4, OP_DEC = 4'd5, OP_NEG = 4'd6, OP_AND = 4'd7,
    OP_OR  = 4'd8, OP_XOR = 4'd9, OP_STC = 4'd10, OP_CLC = 4'd11,
    OP_CMC = 4'd12, OP_STD = 4'd13, OP_CLD = 4'd14, OP_NOP = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} aluSize_e;
  typedef enum logic [1:0] {LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2} logicSel_e;
  typedef enum logic [2:0] {CM_KEEP, CM_ARITH, CM_SET, CM_CLEAR, CM_FLIP} carryMode_e;

  typedef struct packed {
    logic       doSub;     // subtract: invert y, carry-in means no borrow
    logic       xZero;     // negate: x = 0, y = opA
    logic       yOne;      // inc/dec: y = 1
    logic       useCf;     // adc/sbb: take stored carry
    logic       isLogic;
    logicSel_e  lgSel;
    logic       wrResult;
    logic       wrStatus;  // OF SF ZF AF PF
    carryMode_e cfMode;
    logic       wrDir;
    logic       dirVal;
  } aluCtrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import aluflag_pkg::*;
(
  input  logic     valid,
  input  aluOp_e   op,
  output aluCtrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.lgSel  = LG_AND;
    ctrl.cfMode = CM_KEEP;
    if (valid) begin
      unique case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
          ctrl.doSub    = (op == OP_SUB) || (op == OP_SBB);
          ctrl.useCf    = (op == OP_ADC) || (op == OP_SBB);
          ctrl.wrResult = 1'b1;
          ctrl.wrStatus = 1'b1;
          ctrl.cfMode   = CM_ARITH;
        end
        OP_INC, OP_DEC: begin
          ctrl.doSub    = (op == OP_DEC);
          ctrl.yOne     = 1'b1;
          ctrl.wrResult = 1'b1;
          ctrl.wrStatus = 1'b1;
        end
        OP_NEG: begin
          ctrl.doSub    = 1'b1;
          ctrl.xZero    = 1'b1;
          ctrl.wrResult = 1'b1;
          ctrl.wrStatus = 1'b1;
          ctrl.cfMode   = CM_ARITH;
        end
        OP_AND, OP_OR, OP_XOR: begin
          ctrl.isLogic  = 1'b1;
          ctrl.lgSel    = (op == OP_AND) ? LG_AND : (op == OP_OR) ? LG_OR : LG_XOR;
          ctrl.wrResult = 1'b1;
          ctrl.wrStatus = 1'b1;
          ctrl.cfMode   = CM_CLEAR;
        end
        OP_STC: ctrl.cfMode = CM_SET;
        OP_CLC: ctrl.cfMode = CM_CLEAR;
        OP_CMC: ctrl.cfMode = CM_FLIP;
        OP_STD, OP_CLD: begin
          ctrl.wrDir  = 1'b1;
          ctrl.dirVal = (op == OP_STD);
        end
        default: ctrl = ctrl;
      endcase
    end
  end

  // Flag-only operations never write the result (R10, R11)
  always_comb begin
    if (ctrl.wrDir) assert (!ctrl.wrResult && !ctrl.wrStatus && ctrl.cfMode == CM_KEEP)
      else $error("assert_dir_isolated_R11");
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  aluCtrl_t          ctrl,
  input  aluSize_e          size,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cfIn,
  output logic [DATA_W-1:0] res,
  output logic              cfOut,
  output logic              ofOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              afOut,
  output logic              pfOut
);
  localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] MASK_W = {{(DATA_W-16){1'b0}}, 16'hFFFF};
  localparam logic [DATA_W-1:0] MASK_D = {{(DATA_W-32){1'b0}}, 32'hFFFF_FFFF};
  localparam logic [DATA_W-1:0] MASK_Q = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ONE    = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] mask, signMask, aM, bM, xOp, yRaw, yOp, arithRes, logicRes;
  logic [DATA_W:0]   sum;
  logic [4:0]        nib;
  logic              cin, carryRaw, sx, sy, sr;

  always_comb begin
    unique case (size)
      SZ_B:    mask = MASK_B;
      SZ_W:    mask = MASK_W;
      SZ_D:    mask = MASK_D;
      default: mask = MASK_Q;
    endcase
  end

  assign signMask = mask ^ (mask >> 1);
  assign aM   = opA & mask;
  assign bM   = opB & mask;
  assign xOp  = ctrl.xZero ? '0 : aM;
  assign yRaw = ctrl.xZero ? aM : (ctrl.yOne ? ONE : bM);
  assign yOp  = ctrl.doSub ? (~yRaw & mask) : yRaw;
  assign cin  = ctrl.useCf ? (cfIn ^ ctrl.doSub) : ctrl.doSub;

  assign sum      = {1'b0, xOp} + {1'b0, yOp} + {{DATA_W{1'b0}}, cin};
  assign carryRaw = |(sum & ~{1'b0, mask});
  assign arithRes = sum[DATA_W-1:0] & mask;
  assign nib      = {1'b0, xOp[3:0]} + {1'b0, yOp[3:0]} + {4'b0, cin};

  always_comb begin
    unique case (ctrl.lgSel)
      LG_AND:  logicRes = aM & bM;
      LG_OR:   logicRes = aM | bM;
      default: logicRes = aM ^ bM;
    endcase
  end

  assign res = ctrl.isLogic ? logicRes : arithRes;
  assign sx  = |(xOp & signMask);
  assign sy  = |(yOp & signMask);
  assign sr  = |(res & signMask);

  assign cfOut = carryRaw ^ ctrl.doSub;
  assign afOut = ctrl.isLogic ? 1'b0 : (nib[4] ^ ctrl.doSub);
  assign ofOut = ctrl.isLogic ? 1'b0 : ((sx == sy) && (sr != sx));
  assign sfOut = sr;
  assign zfOut = (res == '0);
  assign pfOut = ~^res[7:0];

  // Result never has bits above the selected width (R2)
  always_comb begin
    assert ((res & ~mask) == '0) else $error("assert_result_masked_R2");
  end
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import aluflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] dpRes;
  logic cfQ, pfQ, afQ, zfQ, sfQ, dfQ, ofQ;
  logic cfN, ofN, sfN, zfN, afN, pfN;

  alu_ctrl u_ctrl (.valid(valid), .op(aluOp_e'(opcode)), .ctrl(ctrl));

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .ctrl(ctrl), .size(aluSize_e'(size)), .opA(opA), .opB(opB), .cfIn(cfQ),
    .res(dpRes), .cfOut(cfN), .ofOut(ofN), .sfOut(sfN), .zfOut(zfN),
    .afOut(afN), .pfOut(pfN)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      {cfQ, pfQ, afQ, zfQ, sfQ, dfQ, ofQ} <= '0;
    end else begin
      if (ctrl.wrResult) result <= dpRes;
      if (ctrl.wrStatus) begin
        ofQ <= ofN; sfQ <= sfN; zfQ <= zfN; afQ <= afN; pfQ <= pfN;
      end
      unique case (ctrl.cfMode)
        CM_ARITH: cfQ <= cfN;
        CM_SET:   cfQ <= 1'b1;
        CM_CLEAR: cfQ <= 1'b0;
        CM_FLIP:  cfQ <= ~cfQ;
        default:  cfQ <= cfQ;
      endcase
      if (ctrl.wrDir) dfQ <= ctrl.dirVal;
    end
  end

  always_comb begin
    flags        = 12'h002;
    flags[FB_CF] = cfQ;
    flags[FB_PF] = pfQ;
    flags[FB_AF] = afQ;
    flags[FB_ZF] = zfQ;
    flags[FB_SF] = sfQ;
    flags[FB_DF] = dfQ;
    flags[FB_OF] = ofQ;
  end

  assert_inc_dec_keep_cf_R3: assert property (@(posedge clk) disable iff (rst)
    valid && (opcode == OP_INC || opcode == OP_DEC) |=> flags[FB_CF] == $past(flags[FB_CF]));
  assert_neg_carry_R4: assert property (@(posedge clk) disable iff (rst)
    valid && opcode == OP_NEG |=> flags[FB_CF] == (result != '0));
  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (rst)
    valid && opcode <= OP_XOR |=> flags[FB_ZF] == (result == '0));
  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (rst)
    valid && (opcode == OP_AND || opcode == OP_OR || opcode == OP_XOR)
    |=> !flags[FB_CF] && !flags[FB_OF] && !flags[FB_AF]);
  assert_carry_ops_R10: assert property (@(posedge clk) disable iff (rst)
    valid && (opcode == OP_STC || opcode == OP_CLC || opcode == OP_CMC)
    |=> flags[11:1] == $past(flags[11:1]) && result == $past(result));
  assert_dir_ops_R11: assert property (@(posedge clk) disable iff (rst)
    valid && (opcode == OP_STD || opcode == OP_CLD)
    |=> {flags[11], flags[9:0]} == $past({flags[11], flags[9:0]}) && $stable(result));
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(flags) && $stable(result));
endmodule

// File: tb/tb_alu_flagged.sv
module tb_alu_flagged;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;

  logic clk = 1'b0, rst = 1'b1, valid = 1'b0;
  logic [3:0] opcode = '0;
  logic [1:0] size = '0;
  logic [DATA_W-1:0] opA = '0, opB = '0, result;
  logic [11:0] flags;

  int nChecks = 0, nFails = 0;
  logic [63:0] expRes = '0;
  logic [11:0] expFlags = 12'h002;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flagged #(.DATA_W(DATA_W)) dut (.clk(clk), .rst(rst), .valid(valid), .opcode(opcode),
    .size(size), .opA(opA), .opB(opB), .result(result), .flags(flags));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic signed [65:0] sext(input logic [63:0] v, input int w);
    logic [65:0] t = {2'b0, v};
    for (int i = w; i < 66; i++) t[i] = v[w-1];
    return signed'(t);
  endfunction

  function automatic string tagOf(input logic [3:0] op);
    if (op <= 3) return "R2";
    if (op <= 5) return "R3";
    if (op == 6) return "R4";
    if (op <= 9) return "R9";
    if (op <= 12) return "R10";
    if (op <= 14) return "R11";
    return "R12";
  endfunction

  // Reference model updating expRes/expFlags
  task automatic model(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    int w = 8 << sz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] am = a & mask, bm = b & mask, x, y, r;
    logic [64:0] wide;
    logic ci, c, h, ov;
    logic signed [65:0] s, maxPos, minNeg;
    logic [11:0] f = expFlags;
    maxPos = (66'sd1 <<< (w-1)) - 66'sd1;
    minNeg = -(66'sd1 <<< (w-1));
    if (op <= 9) begin
      if (op == 0 || op == 1 || op == 4) begin
        y = (op == 4) ? 64'd1 : bm;
        ci = (op == 1) ? f[0] : 1'b0;
        wide = {1'b0, am} + {1'b0, y} + {64'd0, ci};
        r = wide[63:0] & mask;
        c = wide > {1'b0, mask};
        h = ({1'b0, am[3:0]} + {1'b0, y[3:0]} + {4'd0, ci}) > 5'd15;
        s = sext(am, w) + sext(y, w) + {65'd0, ci};
        ov = (s > maxPos) || (s < minNeg);
      end else if (op <= 6) begin
        x = (op == 6) ? 64'd0 : am;
        y = (op == 5) ? 64'd1 : (op == 6) ? am : bm;
        ci = (op == 3) ? f[0] : 1'b0;
        r = (x - y - {63'd0, ci}) & mask;
        c = {1'b0, x} < ({1'b0, y} + {64'd0, ci});
        h = {1'b0, x[3:0]} < ({1'b0, y[3:0]} + {4'd0, ci});
        s = sext(x, w) - sext(y, w) - {65'd0, ci};
        ov = (s > maxPos) || (s < minNeg);
      end else begin
        r = (op == 7) ? (am & bm) : (op == 8) ? (am | bm) : (am ^ bm);
        c = 0; h = 0; ov = 0;
      end
      expRes = r;
      if (op != 4 && op != 5) f[0] = c;
      f[2] = ~^r[7:0]; f[4] = h; f[6] = (r == 0); f[7] = r[w-1]; f[11] = ov;
    end else if (op == 10) f[0] = 1;
    else if (op == 11) f[0] = 0;
    else if (op == 12) f[0] = ~f[0];
    else if (op == 13) f[10] = 1;
    else if (op == 14) f[10] = 0;
    expFlags = f;
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic doOp(input logic [3:0] op, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
    valid = 1; opcode = op; size = sz; opA = a; opB = b;
    model(op, sz, a, b);
    @(posedge clk); #1;
    check({tagOf(op), " result"}, result, expRes);
    check({tagOf(op), " flags"}, {52'd0, flags}, {52'd0, expFlags});
    @(negedge clk);
    valid = 0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset result", result, 0);
    check("R1 reset flags", {52'd0, flags}, 64'h002);

    // R3: carry held through INC wrap at 16 bits
    doOp(4'd10, 0, 0, 0);
    doOp(4'd4, 1, 64'h1234_0000_0000_FFFF, 0);
    check("R3 inc wrap zero", result, 0);
    check("R3 inc keeps cf", {63'd0, flags[0]}, 1);
    check("R7 zero set", {63'd0, flags[6]}, 1);
    doOp(4'd11, 0, 0, 0);
    doOp(4'd5, 2, 0, 0);
    check("R3 dec keeps cf clear", {63'd0, flags[0]}, 0);
    check("R7 sign dword", {63'd0, flags[7]}, 1);
    // R4: negate zero and nonzero with carry preset
    doOp(4'd10, 0, 0, 0);
    doOp(4'd6, 3, 0, 64'hFFFF);
    check("R4 neg zero cf", {63'd0, flags[0]}, 0);
    doOp(4'd6, 0, 64'hFF01, 0);
    check("R4 neg result", result, 64'hFF);
    check("R4 neg nonzero cf", {63'd0, flags[0]}, 1);
    // R5: parity uses low byte only
    doOp(4'd9, 1, 64'h0103, 0);
    check("R5 parity low byte", {63'd0, flags[2]}, 1);
    // R6: aux carry
    doOp(4'd0, 0, 64'h0F, 64'h01);
    check("R6 aux carry add", {63'd0, flags[4]}, 1);
    doOp(4'd2, 0, 64'h10, 64'h01);
    check("R6 aux borrow sub", {63'd0, flags[4]}, 1);
    // R8: signed overflow
    doOp(4'd0, 0, 64'h7F, 64'h01);
    check("R8 overflow byte", {63'd0, flags[11]}, 1);
    doOp(4'd2, 3, 64'h8000_0000_0000_0000, 1);
    check("R8 overflow qword sub", {63'd0, flags[11]}, 1);
    // R2: adc chain with carry-in
    doOp(4'd0, 2, 64'hFFFF_FFFF, 1);
    doOp(4'd1, 2, 5, 6);
    check("R2 adc carry-in", result, 12);
    // R11: direction ops
    doOp(4'd13, 0, 0, 0);
    check("R11 std", {63'd0, flags[10]}, 1);
    // R12: idle cycles and opcode 15
    opA = '1; opB = '1; opcode = 4'd0; valid = 0;
    @(posedge clk); #1;
    check("R12 idle result", result, expRes);
    check("R12 idle flags", {52'd0, flags}, {52'd0, expFlags});
    @(negedge clk);
    doOp(4'd15, 3, '1, '1);
    check("R12 reserved bits", {52'd0, flags & 12'h32A}, 64'h002);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = {$urandom, $urandom}, b = {$urandom, $urandom};
      if ($urandom % 4 == 0) a = a & 64'hFF;
      if ($urandom % 8 == 0) b = a;
      doOp(4'($urandom % 15), 2'($urandom), a, b);
    end
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule